// File: doc/BRIEF.md
# Synchronous Burst Memory Control Front-End

This block is the control front-end of a synchronous burst memory. On every rising clock edge it samples three chip selects, two address strobes, a burst-step input and a set of write controls. From these it picks one of four cycle kinds:

- **Deselect**: ends any burst.
- **Burst start**: begins at the external address.
- **Burst step**: moves to the next address of the four-beat group.
- **Burst hold**: stays on the current address.

Each of these cycles then reads from or writes to a small internal array. Writes are masked per 9-bit byte lane. Read data is registered and returned on a 36-bit bus. A drive flag models the tristate enable of that bus, and a read-valid flag marks the cycles that carry data.

There are two address strobes, and they do not behave alike.

- **CPU-side strobe**: always starts a read. It is ignored while the first chip select is inactive.
- **Controller-side strobe**: starts a read or a write according to the write controls. A write can still follow a CPU-started read: the next cycle is a hold cycle with a write requested, and it lands on the same address.

Two beat orders are supported, selected by an input pin. Interleaved order exclusive-ORs the beat number into the two low address bits. Linear order adds the beat number to them, wrapping modulo 4.

Top module: `sbs_ctrl_top`

## Requirements
- R1: The chip counts as selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A strobe cycle with `sel0_n`=0 while the chip is not selected is a deselect: nothing is written or read, and `rvalid` is 0 after that edge.
- R2: A cycle with `strb_ctl_n`=0 and `sel0_n`=1 is a deselect whatever `strb_cpu_n` is. After that edge `rvalid` and `dq_drive` are 0.
- R3: `strb_cpu_n`=0 with `sel0_n`=0 and the chip selected starts a burst at `addr`. That cycle is a read even when the write controls request a write.
- R4: `strb_cpu_n`=0 with `sel0_n`=1 has no effect. With `strb_ctl_n`=1 the cycle is then a burst step or hold, not a deselect.
- R5: `strb_cpu_n`=1, `strb_ctl_n`=0 and the chip selected starts a burst at `addr`. It is a write when a write is decoded (R7) and a read otherwise.
- R6: With both strobes high, `step_n`=0 moves to the next beat and `step_n`=1 keeps the current beat. Beat k of a burst starting at address S keeps S[5:2]. Its low two bits are S[1:0] XOR k when `linear_order`=0, and S[1:0]+k mod 4 when `linear_order`=1.
- R7: Write decode:
  - `wr_all_n`=0 writes all four lanes.
  - Otherwise a write happens only when `wr_byte_n`=0 and some `lane_wr_n` bit is 0, and only those lanes are written.
  - Lane i is `wdata`/`rdata` bits [9i+8:9i].
  - Every other combination is a read.
- R8: `out_en_n` acts without a clock. While it is 1, `dq_drive` is 0 and `rdata` is 0, even after a read.
- R9: A hold cycle that requests a write, directly after a CPU-started read, writes to that same address.
- R10: After reset `rvalid` and `dq_drive` are 0 and no burst is active.
- R11: A deselect ends the burst. Later step or hold cycles neither read (`rvalid` stays 0) nor write until a new burst starts.
- R12: Read data and `rvalid` appear one clock after the edge that uses the address. Before that edge the outputs still show the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (6) | External word address |
| sel0_n | input | 1 | First chip select, active low; also gates the CPU strobe |
| sel1 | input | 1 | Second chip select, active high |
| sel2_n | input | 1 | Third chip select, active low |
| strb_cpu_n | input | 1 | CPU-side address strobe, active low, read-only start |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst step, active low; high holds the beat |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane-masked write enable, active low |
| lane_wr_n | input | LANES (4) | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| linear_order | input | 1 | 1 = linear beat order, 0 = interleaved |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Read data; 0 while not driven |
| dq_drive | output | 1 | Data bus driven (tristate enable) |
| rvalid | output | 1 | Registered read-valid flag |

## Verification
On every cycle the assertions check the following properties:
- A burst start always arms the sequencer at beat 0.
- A step cycle advances the beat by one, and a hold cycle leaves it unchanged.
- A deselect clears the active burst and leaves `rvalid` low.
- A CPU strobe cycle, or a strobe cycle without full chip select, never writes.
- Every write enables at least one lane.

Only the bench scenarios can show that data lands in the right lanes and addresses. These scenarios cover:
- the beat orders, across both modes and several start offsets;
- that the unclocked output enable cuts the bus within a cycle;
- that a write following a CPU-started read reaches the same word;
- that writes attempted while deselected leave memory unchanged.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Burst group of four beats: two low address bits are sequenced
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_BEGIN = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_t;

    typedef struct packed {
        cyc_t cyc;
        logic wr;
    } cmd_t;

    // Low address bits of beat k for a burst that started at slot 'start'
    function automatic logic [BURST_W-1:0] beat_slot(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] k,
        input logic               linear
    );
        return linear ? BURST_W'(start + k) : (start ^ k);
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    output cmd_t             cmd,
    output logic [LANES-1:0] lane_mask
);

    logic sel_ok;
    logic wr_req;

    always_comb begin
        sel_ok    = !sel0_n && sel1 && !sel2_n;
        wr_req    = !wr_all_n || (!wr_byte_n && (lane_wr_n != '1));
        lane_mask = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_wr_n : '0);

        cmd.wr = 1'b0;
        if (!strb_ctl_n && sel0_n) begin
            // controller strobe with first select inactive: CPU strobe ignored
            cmd.cyc = CYC_DESEL;
        end else if (!sel0_n && !strb_cpu_n) begin
            // CPU strobe has priority and always reads
            cmd.cyc = sel_ok ? CYC_BEGIN : CYC_DESEL;
        end else if (!sel0_n && !strb_ctl_n) begin
            cmd.cyc = sel_ok ? CYC_BEGIN : CYC_DESEL;
            cmd.wr  = sel_ok && wr_req;
        end else begin
            // no effective strobe: step or hold the running burst
            cmd.cyc = step_n ? CYC_HOLD : CYC_NEXT;
            cmd.wr  = wr_req;
        end
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_t              cyc,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              linear,
    output logic [ADDR_W-1:0] use_addr,
    output logic              live
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic                 active;
    logic [ADDR_W-1:0]    base;
    logic [BURST_W-1:0]   cnt;
    logic [BURST_W-1:0]   cnt_nx;
    logic [BURST_W-1:0]   slot;

    always_comb begin
        cnt_nx   = BURST_W'(cnt + 1'b1);
        slot     = '0;
        use_addr = ext_addr;
        live     = 1'b0;
        case (cyc)
            CYC_BEGIN: begin
                use_addr = ext_addr;
                live     = 1'b1;
            end
            CYC_NEXT: begin
                slot     = beat_slot(base[BURST_W-1:0], cnt_nx, linear);
                use_addr = {base[ADDR_W-1 -: HI_W], slot};
                live     = active;
            end
            CYC_HOLD: begin
                slot     = beat_slot(base[BURST_W-1:0], cnt, linear);
                use_addr = {base[ADDR_W-1 -: HI_W], slot};
                live     = active;
            end
            default: begin
                use_addr = ext_addr;
                live     = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            cnt    <= '0;
        end else begin
            case (cyc)
                CYC_BEGIN: begin
                    active <= 1'b1;
                    base   <= ext_addr;
                    cnt    <= '0;
                end
                CYC_NEXT: if (active) cnt <= cnt_nx;
                CYC_DESEL: active <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_BEGIN_ARMS: assert property (@(posedge clk) disable iff (rst)
        cyc == CYC_BEGIN |=> (active && cnt == '0)); // R5

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_NEXT && active) |=> cnt == BURST_W'($past(cnt) + 1)); // R6

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        cyc == CYC_HOLD |=> $stable(cnt)); // R6

    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cyc == CYC_DESEL |=> !active); // R11

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    re,
    input  logic [LANES-1:0]        mask,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
            if (re)            rdata[g*LANE_W +: LANE_W] <= bank[addr];
        end
    end

endmodule

// File: rtl/sbs_ctrl_top.sv
module sbs_ctrl_top
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    step_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic                    linear_order,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    dq_drive,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_t              cmd;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] use_addr;
    logic              live;
    logic              mem_we;
    logic              mem_re;
    logic              rvalid_q;
    logic [DATA_W-1:0] rd_q;

    sbs_cmd_decode #(.LANES(LANES)) u_dec (
        .sel0_n     (sel0_n),
        .sel1       (sel1),
        .sel2_n     (sel2_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .step_n     (step_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_wr_n  (lane_wr_n),
        .cmd        (cmd),
        .lane_mask  (lane_mask)
    );

    sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cyc      (cmd.cyc),
        .ext_addr (addr),
        .linear   (linear_order),
        .use_addr (use_addr),
        .live     (live)
    );

    assign mem_we = live && cmd.wr;
    assign mem_re = live && !cmd.wr;

    sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .mask  (lane_mask),
        .addr  (use_addr),
        .wdata (wdata),
        .rdata (rd_q)
    );

    always_ff @(posedge clk) begin
        if (rst) rvalid_q <= 1'b0;
        else     rvalid_q <= mem_re;
    end

    // output enable is not sampled: it gates the bus combinationally
    assign dq_drive = rvalid_q && !out_en_n;
    assign rdata    = dq_drive ? rd_q : '0;
    assign rvalid   = rvalid_q;

    AST_CPU_STRB_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sel0_n && !strb_cpu_n) |-> !mem_we); // R3

    AST_UNSEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sel0_n && !(sel1 && !sel2_n) && !(strb_cpu_n && strb_ctl_n)) |-> !mem_we); // R1

    AST_DESEL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl_n && sel0_n) |=> !rvalid_q); // R2

    AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (lane_mask != '0)); // R7

endmodule

// File: tb/tb_sbs_ctrl_top.sv
module tb_sbs_ctrl_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr;
    logic        sel0_n, sel1, sel2_n;
    logic        strb_cpu_n, strb_ctl_n, step_n;
    logic        wr_all_n, wr_byte_n;
    logic [3:0]  lane_wr_n;
    logic        out_en_n, linear_order;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        dq_drive, rvalid;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sbs_ctrl_top dut (
        .clk(clk), .rst(rst), .addr(addr),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .linear_order(linear_order),
        .wdata(wdata), .rdata(rdata), .dq_drive(dq_drive), .rvalid(rvalid)
    );

    // {linear_order, start address}
    localparam logic [6:0] VEC [8] = '{
        7'h00, 7'h01, 7'h06, 7'h0B, 7'h50, 7'h51, 7'h66, 7'h7B
    };

    function automatic logic [35:0] pat(input logic [5:0] a);
        return {a, 3'd1, a, 3'd2, a, 3'd3, a, 3'd4};
    endfunction

    function automatic logic [5:0] beat_addr(input logic [5:0] s, input int k, input logic lin);
        logic [1:0] kk;
        kk = 2'(k);
        return {s[5:2], lin ? 2'(s[1:0] + kk) : (s[1:0] ^ kk)};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel0_n = 0; sel1 = 1; sel2_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 4'hF;
        out_en_n = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr1(input logic [5:0] a, input logic [35:0] d);
        idle(); strb_ctl_n = 0; addr = a; wr_all_n = 0; wdata = d;
        tick();
    endtask

    task automatic rd_begin(input logic [5:0] a);
        idle(); strb_cpu_n = 0; addr = a;
        tick();
    endtask

    task automatic desel();
        idle(); sel0_n = 1; strb_ctl_n = 0;
        tick();
    endtask

    task automatic step();
        idle(); step_n = 0;
        tick();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [35:0] e;
        rst = 1; idle(); addr = '0; wdata = '0; linear_order = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 rvalid after reset", {35'd0, rvalid}, 36'd0);
        chk("R10 dq_drive after reset", {35'd0, dq_drive}, 36'd0);
        rst = 0;
        // R10: no burst active, so a step cycle must not read
        step();
        chk("R10 no burst after reset", {35'd0, rvalid}, 36'd0);

        // fill memory with single-beat controller-strobe writes (R5)
        for (int a = 0; a < 64; a++) wr1(6'(a), pat(6'(a)));
        desel();

        // table walk: burst orders (R6), CPU start (R3), latency (R12)
        for (int i = 0; i < 8; i++) begin
            linear_order = VEC[i][6];
            rd_begin(VEC[i][5:0]);
            chk("R3 beat0 rvalid", {35'd0, rvalid}, 36'd1);
            chk("R12 beat0 data", rdata, pat(VEC[i][5:0]));
            for (int k = 1; k < 4; k++) begin
                step();
                chk("R6 beat data", rdata, pat(beat_addr(VEC[i][5:0], k, VEC[i][6])));
            end
        end
        linear_order = 0;

        // R5: controller strobe without write request reads
        idle(); strb_ctl_n = 0; addr = 6'd20; tick();
        chk("R5 ctl read data", rdata, pat(6'd20));

        // R12: before the edge, outputs still show the previous cycle
        desel();
        idle(); strb_cpu_n = 0; addr = 6'd3;
        #2;
        chk("R12 rvalid before edge", {35'd0, rvalid}, 36'd0);
        tick();
        chk("R12 rvalid after edge", {35'd0, rvalid}, 36'd1);
        chk("R12 data after edge", rdata, pat(6'd3));

        // R2: deselect with CPU strobe also low
        idle(); sel0_n = 1; strb_ctl_n = 0; strb_cpu_n = 0; addr = 6'd4; tick();
        chk("R2 rvalid", {35'd0, rvalid}, 36'd0);
        chk("R2 dq_drive", {35'd0, dq_drive}, 36'd0);
        // R11: step and hold after deselect neither read nor write
        step();
        chk("R11 step after desel", {35'd0, rvalid}, 36'd0);
        idle(); wr_all_n = 0; wdata = 36'h0; tick();
        chk("R11 hold after desel", {35'd0, rvalid}, 36'd0);
        rd_begin(6'd3);
        chk("R11 no write to base", rdata, pat(6'd3));

        // R1: not fully selected, controller write attempt
        idle(); sel1 = 0; strb_ctl_n = 0; addr = 6'd5; wr_all_n = 0; wdata = '0; tick();
        chk("R1 sel1 low rvalid", {35'd0, rvalid}, 36'd0);
        idle(); sel2_n = 1; strb_cpu_n = 0; addr = 6'd5; tick();
        chk("R1 sel2_n high rvalid", {35'd0, rvalid}, 36'd0);
        rd_begin(6'd5);
        chk("R1 memory unchanged", rdata, pat(6'd5));

        // R3: CPU strobe with write requested still reads
        idle(); strb_cpu_n = 0; addr = 6'd7; wr_all_n = 0; wdata = '0; tick();
        chk("R3 read despite write", rdata, pat(6'd7));
        rd_begin(6'd7);
        chk("R3 no write happened", rdata, pat(6'd7));

        // R4: CPU strobe ignored with sel0_n high; cycle steps the burst
        rd_begin(6'd8);
        idle(); sel0_n = 1; strb_cpu_n = 0; step_n = 0; tick();
        chk("R4 rvalid", {35'd0, rvalid}, 36'd1);
        chk("R4 stepped data", rdata, pat(6'd9));

        // R6: hold keeps the beat (linear from 17)
        linear_order = 1;
        rd_begin(6'd17);
        step();
        chk("R6 step linear", rdata, pat(6'd18));
        idle(); tick();
        chk("R6 hold", rdata, pat(6'd18));
        step();
        chk("R6 step after hold", rdata, pat(6'd19));
        linear_order = 0;

        // R7: lane-masked write, lanes 0 and 2
        idle(); strb_ctl_n = 0; addr = 6'd10; wr_byte_n = 0; lane_wr_n = 4'b1010;
        wdata = '1; tick();
        chk("R7 write gives no rvalid", {35'd0, rvalid}, 36'd0);
        e = pat(6'd10);
        e[8:0] = 9'h1FF; e[26:18] = 9'h1FF;
        rd_begin(6'd10);
        chk("R7 lanes 0 and 2", rdata, e);
        // R7: byte enable without lanes is a read, lanes without byte enable too
        idle(); strb_ctl_n = 0; addr = 6'd10; wr_byte_n = 0; lane_wr_n = 4'hF; wdata = '0; tick();
        chk("R7 no lane selected reads", rdata, e);
        idle(); strb_ctl_n = 0; addr = 6'd10; wr_byte_n = 1; lane_wr_n = 4'h0; wdata = '0; tick();
        chk("R7 lanes without enable reads", rdata, e);

        // R8: unclocked output enable
        rd_begin(6'd11);
        out_en_n = 1; #1;
        chk("R8 drive off", {35'd0, dq_drive}, 36'd0);
        chk("R8 rdata zero", rdata, 36'd0);
        chk("R8 rvalid still set", {35'd0, rvalid}, 36'd1);
        out_en_n = 0; #1;
        chk("R8 drive back on", rdata, pat(6'd11));

        // R9: write in hold cycle after CPU-started read
        rd_begin(6'd12);
        idle(); wr_all_n = 0; wdata = 36'h123456789; tick();
        chk("R9 hold write no rvalid", {35'd0, rvalid}, 36'd0);
        rd_begin(6'd12);
        chk("R9 same address written", rdata, 36'h123456789);

        desel();
        finish_run();
    end

endmodule